// File: doc/BRIEF.md
# Rate-1/N Convolutional Encoder

This block takes a stream of single data bits and, for each bit, produces an N-bit parity word. Each parity bit is the modulo-2 sum of selected taps of a short shift register. The taps are set by N generator polynomials, each given as a decimal integer. A further integer, the feedback polynomial, chooses the code family. When it is zero the code is plain feedforward. When it is non-zero the register input is the data bit XORed with a parity of selected state taps, which gives a recursive code. The register length M is one less than the widest polynomial, counted in bits.

Input and output are valid/ready streams. The output word is held in a register until it is accepted, so back-pressure from downstream stalls the input stream. A frame-end flag travels with each bit and comes out with its parity word. After the beat that carries the flag, the shift register clears, so every frame starts from the all-zero state.

Top module: `conv_encoder_top`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid is 0, inReady is 1, and the shift register is all zeros.
- R2: inReady is 0 exactly when outValid is 1 and outReady is 0. A bit is accepted in each cycle where inValid and inReady are both 1.
- R3: While outValid is 1 and outReady is 0, outValid, outData and outLast keep their values on the following clock.
- R4: Each accepted bit produces exactly one output word, and it is valid in the next cycle. outValid falls after a transfer unless a new bit is accepted in the same cycle.
- R5: Define a window of M+1 bits. Bit M holds the data bit XOR the feedback bit, and bits M-1..0 hold the current state. Output bit j is the XOR of that window ANDed with the low M+1 bits of generator polynomial j. Bit 0 is the least significant bit of outData.
- R6: The feedback bit is the XOR of the state ANDed with the low M bits of the feedback polynomial. A feedback polynomial of zero gives a feedforward code.
- R7: After an accepted bit that is not marked last, the state becomes bits M..1 of the window.
- R8: outLast equals the inLast value of the bit that produced the word.
- R9: After an accepted bit marked last, the state is all zeros. A following frame encodes as if it came straight from reset.
- R10: The defaults are polynomials 121 (output bit 0) and 91 (output bit 1) with no feedback, so M = 6. In this configuration, a 1 followed by six 0s from the zero state gives words whose bit j, for k = 0..6, is bit 6-k of polynomial j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input bit is offered |
| inReady | output | 1 | Encoder can take a bit this cycle |
| inBit | input | 1 | Data bit |
| inLast | input | 1 | Marks the final bit of a frame |
| outValid | output | 1 | Parity word is present |
| outReady | input | 1 | Downstream takes the word this cycle |
| outData | output | NUM_OUT | Parity word, bit j from polynomial j |
| outLast | output | 1 | Frame-end flag carried with the word |

## Verification
The assertions assume that the environment holds reset synchronous to the clock. They also assume it drives inputs that are never X once reset is released. They do not require a source to keep inValid high while it waits: an offered bit may be withdrawn before acceptance, because each bit counts only on its handshake. The bench drives all inputs on the falling edge with two-valued values. It includes withdrawn offers, long stalls and frame-end flags at random positions. All of this stays inside those assumptions.

// File: rtl/conv_encoder_pkg.sv
package conv_encoder_pkg;

  // Strobes from the handshake control to the shift datapath
  typedef struct packed {
    logic advance;   // a bit is taken at this edge
    logic restart;   // the taken bit closes a frame
  } enc_strobe_t;

  // Number of bits needed to hold v (0 for v == 0)
  function automatic int bitLen(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/conv_encoder_ctrl.sv
module conv_encoder_ctrl
  import conv_encoder_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output enc_strobe_t strobe
);

  logic validQ;
  logic accept;

  assign inReady = !validQ || outReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (accept) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assign outValid       = validQ;
  assign strobe.advance = accept;
  assign strobe.restart = accept && inLast;

endmodule

// File: rtl/conv_encoder_datapath.sv
module conv_encoder_datapath
  import conv_encoder_pkg::*;
#(
  parameter int unsigned          NUM_OUT   = 2,
  parameter int unsigned          MEM       = 6,
  parameter logic [NUM_OUT*32-1:0] GEN_POLYS = {32'd91, 32'd121},
  parameter int unsigned          FB_POLY   = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  enc_strobe_t        strobe,
  input  logic               inBit,
  input  logic               inLast,
  output logic [NUM_OUT-1:0] outData,
  output logic               outLast
);

  localparam int unsigned WIN = MEM + 1;

  logic [MEM-1:0]     state;
  logic               feedback;
  logic [WIN-1:0]     window;
  logic [NUM_OUT-1:0] parity;

  // Variant picked by the feedback polynomial
  generate
    if (FB_POLY == 0) begin : g_feedforward
      assign feedback = 1'b0;
    end else begin : g_recursive
      localparam logic [31:0]    FB_VEC  = FB_POLY;
      localparam logic [MEM-1:0] FB_MASK = FB_VEC[MEM-1:0];
      assign feedback = ^(state & FB_MASK);
    end
  endgenerate

  assign window = {inBit ^ feedback, state};

  generate
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_tap
      localparam logic [31:0]    POLY_J = GEN_POLYS[j*32 +: 32];
      localparam logic [WIN-1:0] MASK_J = POLY_J[WIN-1:0];
      assign parity[j] = ^(window & MASK_J);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= '0;
      outData <= '0;
      outLast <= 1'b0;
    end else if (strobe.advance) begin
      outData <= parity;
      outLast <= inLast;
      state   <= strobe.restart ? '0 : window[WIN-1:1];
    end
  end

endmodule

// File: rtl/conv_encoder_top.sv
module conv_encoder_top
  import conv_encoder_pkg::*;
#(
  parameter int unsigned          NUM_OUT   = 2,
  parameter logic [NUM_OUT*32-1:0] GEN_POLYS = {32'd91, 32'd121},
  parameter int unsigned          FB_POLY   = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inBit,
  input  logic               inLast,
  output logic               outValid,
  input  logic               outReady,
  output logic [NUM_OUT-1:0] outData,
  output logic               outLast
);

  function automatic int calcLen();
    int best;
    int len;
    best = bitLen(FB_POLY);
    for (int j = 0; j < int'(NUM_OUT); j++) begin
      len = bitLen(GEN_POLYS[j*32 +: 32]);
      if (len > best) best = len;
    end
    return best;
  endfunction

  localparam int unsigned CONSTR_LEN = calcLen();
  localparam int unsigned MEM        = CONSTR_LEN - 1;

  enc_strobe_t strobe;

  conv_encoder_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  conv_encoder_datapath #(
    .NUM_OUT   (NUM_OUT),
    .MEM       (MEM),
    .GEN_POLYS (GEN_POLYS),
    .FB_POLY   (FB_POLY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inBit   (inBit),
    .inLast  (inLast),
    .outData (outData),
    .outLast (outLast)
  );

endmodule

// File: rtl/conv_encoder_checker.sv
module conv_encoder_checker #(
  parameter int unsigned NUM_OUT = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [NUM_OUT-1:0] outData,
  input logic               outLast
);

  logic seenEdge;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R1: no word is presented right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    seenEdge && !rstN |=> !outValid);

  // R2: a stalled output blocks new input
  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R3: an unaccepted word stays put
  assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R4: an accepted bit yields a word next cycle
  assert_accept_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R4: a drained word with no new bit leaves the output empty
  assert_drain_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

endmodule

bind conv_encoder_top conv_encoder_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast)
);

// File: tb/conv_encoder_top_test.sv
module conv_encoder_top_test;

  localparam int MEM   = 6;
  localparam int POLY0 = 121;
  localparam int POLY1 = 91;
  localparam int FB_R  = 109;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inBit = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic inReadyF, outValidF, outLastF;
  logic inReadyR, outValidR, outLastR;
  logic [1:0] outDataF, outDataR;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  conv_encoder_top uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReadyF),
    .inBit(inBit), .inLast(inLast), .outValid(outValidF), .outReady(outReady),
    .outData(outDataF), .outLast(outLastF));

  conv_encoder_top #(.FB_POLY(FB_R)) uutRec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReadyR),
    .inBit(inBit), .inLast(inLast), .outValid(outValidR), .outReady(outReady),
    .outData(outDataR), .outLast(outLastR));

  // Behavioural model state
  int stF = 0, stR = 0;
  int qF[$];
  int qR[$];
  int kaQ[$];
  bit capture = 0;
  bit holdPend[2];
  int holdWord[2];

  task automatic report(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int xorBits(input int v);
    int p = 0;
    for (int i = 0; i < 32; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  // One bit through the rule: returns {last, p1, p0}, updates state
  function automatic int model(inout int st, input int fb, input bit b, input bit l);
    int fbBit, win, word;
    fbBit = xorBits(st & fb & ((1 << MEM) - 1));
    win   = ((b ^ fbBit) << MEM) | st;
    word  = xorBits(win & POLY0) | (xorBits(win & POLY1) << 1) | (int'(l) << 2);
    st    = l ? 0 : (win >> 1);
    return word;
  endfunction

  task automatic checkSide(input int id, input bit ov, input bit ir,
                           input logic [1:0] od, input bit ol);
    int act, exp;
    act = {29'd0, ol, od};
    report(ir == (!ov || outReady), "R2 ready", ir, !ov || outReady);
    if (holdPend[id]) report(ov && act == holdWord[id], "R3 hold", act, holdWord[id]);
    holdPend[id] = ov && !outReady;
    holdWord[id] = act;
    if (ov && outReady) begin
      if (id == 0) begin
        exp = (qF.size() > 0) ? qF.pop_front() : -1;
        if (capture) kaQ.push_back(act);
      end else begin
        exp = (qR.size() > 0) ? qR.pop_front() : -1;
      end
      report(act == exp, id == 0 ? "R5 R6 R7 R8 feedforward" : "R5 R6 R7 R8 recursive", act, exp);
    end
    if (inValid && ir) begin
      if (id == 0) qF.push_back(model(stF, 0, inBit, inLast));
      else         qR.push_back(model(stR, FB_R, inBit, inLast));
    end
  endtask

  task automatic step(input bit v, input bit b, input bit l, input bit r);
    @(negedge clk);
    inValid = v; inBit = b; inLast = l; outReady = r;
    #1;
    checkSide(0, outValidF, inReadyF, outDataF, outLastF);
    checkSide(1, outValidR, inReadyR, outDataR, outLastR);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    report(!outValidF && !outValidR, "R1 outValid in reset", outValidF, 0);
    report(inReadyF && inReadyR, "R1 inReady in reset", inReadyF, 1);
    @(negedge clk) rstN = 1'b1;
    #1;
    report(!outValidF, "R1 outValid after reset", outValidF, 0);

    // R9: a frame of ones, then the impulse frame must start from zero state
    step(1, 1, 0, 1); step(1, 1, 0, 1); step(1, 1, 0, 1); step(1, 1, 1, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    capture = 1;
    step(1, 1, 0, 1);
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1);
    step(1, 0, 1, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    capture = 0;
    // R10 / R9: known impulse response of the default code
    report(kaQ.size() == 7, "R10 impulse word count", kaQ.size(), 7);
    for (int k = 0; k < 7; k++) begin
      int exp;
      exp = ((POLY0 >> (6 - k)) & 1) | (((POLY1 >> (6 - k)) & 1) << 1) | ((k == 6) << 2);
      if (k < kaQ.size()) report(kaQ[k] == exp, "R9 R10 impulse word", kaQ[k], exp);
    end

    // R3 / R2: long stall with a bit offered
    step(1, 1, 0, 0);
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0);
    step(1, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);

    // Random traffic, both codes compared on every clock
    for (int n = 0; n < 4000; n++)
      step(($urandom % 10) < 7, $urandom % 2, ($urandom % 16) == 0, ($urandom % 10) < 7);
    for (int n = 0; n < 4; n++) step(0, 0, 0, 1);
    report(qF.size() == 0 && qR.size() == 0, "R4 no words lost", qF.size() + qR.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule